// File: doc/BRIEF.md
# Per-Bank DRAM Command Timing Tracker

This block keeps the timing state of every bank in one DRAM rank and turns each access request into a schedule of commands. For each bank it stores whether a row is open and which one. It also stores three earliest-allowed times: one for column (read/write) commands, one for precharge and one for activate. A single shared register holds the time until which the data bus is occupied.

A scheduler presents a request with a bank, a row, a read/write flag and the current cycle count. One cycle later the block reports four things: whether the access hit the open row, the precharge and activate times when those commands are needed, the column command time, and the time at which the burst's data is ready on the bus. Within that same edge it updates the addressed bank's allowed times and the bus occupancy. This lets the next request, including a back-to-back one, see the new state.

Times are absolute cycle counts on a `TIME_W`-bit scale. The surrounding controller supplies them on `curTime`. All timing values are parameters: activate-to-column delay, activate-to-precharge minimum, precharge duration, column-to-data latency, burst length and write recovery.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset no bank has an open row, every allowed time and the bus-busy time are zero, and both hit counters read zero. The first access to any bank is therefore a miss without precharge, with its activate at the request's `curTime`.
- R2: A request whose bank has the requested row open is a hit: `rspHit`=1, `rspPre`=0, `rspAct`=0, and `rspPreTime`/`rspActTime` read 0. Its column time starts from the later of that bank's column-allowed time and `curTime`.
- R3: On a miss to a bank with a different row open, `rspPre`=1 and the precharge is at the later of the bank's precharge-allowed time and `curTime`. The bank's activate-allowed time becomes the larger of its old value and the precharge time plus T_RP.
- R4: On any miss, `rspAct`=1 and the activate is at the later of the bank's activate-allowed time (after R3) and `curTime`. The activate sets precharge-allowed to activate+T_RAS and column-allowed to activate+T_RCD, and the column time starts from activate+T_RCD. On a miss with no open row, `rspPre`=0 and `rspPreTime`=0.
- R5: The column time is never earlier than the previous bus-busy time minus T_CL, where a bus-busy time below T_CL counts as a floor of 0.
- R6: The ready time equals column time + T_CL + T_BURST and becomes the new bus-busy time. Each ready time is at least T_BURST after the previous bus-busy time.
- R7: After every access, the bank's column-allowed time is column time + T_BURST.
- R8: After a write (`reqWrite`=1), the bank's precharge-allowed time is at least ready time + T_WR.
- R9: `rdHitCount` counts hits of reads and `wrHitCount` counts hits of writes. Each counter changes only in the cycle a response is presented.
- R10: `rspValid` is high exactly one cycle after each cycle with `reqValid` high. Cycles without a request leave all bank and bus state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqBank | input | BANK_W | Target bank index |
| reqRow | input | ROW_W | Target row |
| reqWrite | input | 1 | 1 = write, 0 = read |
| curTime | input | TIME_W | Current cycle count |
| rspValid | output | 1 | Response for last cycle's request |
| rspHit | output | 1 | Access hit the open row |
| rspPre | output | 1 | A precharge is needed |
| rspAct | output | 1 | An activate is needed |
| rspPreTime | output | TIME_W | Precharge time, 0 when none |
| rspActTime | output | TIME_W | Activate time, 0 when none |
| rspColTime | output | TIME_W | Column command time |
| rspReadyTime | output | TIME_W | Data ready time |
| rdHitCount | output | CNT_W | Read row hits so far |
| wrHitCount | output | CNT_W | Write row hits so far |

## Verification
The hardest situation to reach is a bank whose command time is bound by a stale allowed time rather than by `curTime`. One example is a write's recovery window that holds off a later precharge. Another is a bus-busy time left by a different bank that pushes a hit's column command back. The stimulus sweeps all banks, rows, directions and idle gaps of zero to two cycles. Back-to-back pairs and row changes keep those windows open when the next request arrives. A long idle stretch then shows every bound lapsing back to `curTime`.

// File: rtl/bank_timing_pkg.sv
package bank_timing_pkg;
  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic commit;   // a request is applied this cycle
    logic needPre;  // close the open row first
    logic needAct;  // open the requested row
    logic isWrite;  // access is a write
  } ctrlStrobe_t;
endpackage

// File: rtl/bank_timing_ctrl.sv
module bank_timing_ctrl
  import bank_timing_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [ROW_W-1:0] reqRow,
  input  logic             lookupOpen,
  input  logic [ROW_W-1:0] lookupRow,
  output ctrlStrobe_t      strobe,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspPre,
  output logic             rspAct,
  output logic [CNT_W-1:0] rdHitCount,
  output logic [CNT_W-1:0] wrHitCount
);
  logic rowHit;

  always_comb begin
    rowHit         = reqValid && lookupOpen && (lookupRow == reqRow);
    strobe.commit  = reqValid;
    strobe.needPre = reqValid && lookupOpen && !rowHit;
    strobe.needAct = reqValid && !rowHit;
    strobe.isWrite = reqWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspHit     <= 1'b0;
      rspPre     <= 1'b0;
      rspAct     <= 1'b0;
      rdHitCount <= '0;
      wrHitCount <= '0;
    end else begin
      rspValid <= reqValid;
      rspHit   <= rowHit;
      rspPre   <= strobe.needPre;
      rspAct   <= strobe.needAct;
      if (rowHit && !reqWrite) rdHitCount <= rdHitCount + 1'b1;
      if (rowHit && reqWrite)  wrHitCount <= wrHitCount + 1'b1;
    end
  end
endmodule

// File: rtl/bank_timing_datapath.sv
module bank_timing_datapath
  import bank_timing_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int TIME_W    = 32,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 8,
  parameter int T_RP      = 3,
  parameter int T_CL      = 4,
  parameter int T_BURST   = 2,
  parameter int T_WR      = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [TIME_W-1:0] curTime,
  output logic              lookupOpen,
  output logic [ROW_W-1:0]  lookupRow,
  output logic [TIME_W-1:0] rspPreTime,
  output logic [TIME_W-1:0] rspActTime,
  output logic [TIME_W-1:0] rspColTime,
  output logic [TIME_W-1:0] rspReadyTime
);
  localparam logic [TIME_W-1:0] RcdT   = TIME_W'(T_RCD);
  localparam logic [TIME_W-1:0] RasT   = TIME_W'(T_RAS);
  localparam logic [TIME_W-1:0] RpT    = TIME_W'(T_RP);
  localparam logic [TIME_W-1:0] ClT    = TIME_W'(T_CL);
  localparam logic [TIME_W-1:0] BurstT = TIME_W'(T_BURST);
  localparam logic [TIME_W-1:0] WrT    = TIME_W'(T_WR);

  function automatic logic [TIME_W-1:0] tMax(input logic [TIME_W-1:0] a,
                                             input logic [TIME_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic              openQ [NUM_BANKS];
  logic [ROW_W-1:0]  rowQ  [NUM_BANKS];
  logic [TIME_W-1:0] colQ  [NUM_BANKS];
  logic [TIME_W-1:0] preQ  [NUM_BANKS];
  logic [TIME_W-1:0] actQ  [NUM_BANKS];
  logic [TIME_W-1:0] busQ;

  logic [TIME_W-1:0] selCol, selPre, selAct;
  logic [TIME_W-1:0] preTimeC, actFloorC, actTimeC, colBaseC, busFloorC;
  logic [TIME_W-1:0] colTimeC, readyC, newPreC, newActC, newColC;

  always_comb begin
    lookupOpen = openQ[reqBank];
    lookupRow  = rowQ[reqBank];
    selCol     = colQ[reqBank];
    selPre     = preQ[reqBank];
    selAct     = actQ[reqBank];

    // close an open row no earlier than its precharge window allows
    preTimeC  = tMax(selPre, curTime);
    actFloorC = strobe.needPre ? tMax(selAct, preTimeC + RpT) : selAct;
    actTimeC  = tMax(actFloorC, curTime);

    // column start: after row opening on a miss, else bank window
    colBaseC  = strobe.needAct ? (actTimeC + RcdT) : tMax(selCol, curTime);
    busFloorC = (busQ >= ClT) ? (busQ - ClT) : '0;
    colTimeC  = tMax(colBaseC, busFloorC);
    readyC    = colTimeC + ClT + BurstT;

    newPreC = strobe.needAct ? (actTimeC + RasT) : selPre;
    if (strobe.isWrite) newPreC = tMax(newPreC, readyC + WrT);
    newActC = actFloorC;
    newColC = colTimeC + BurstT;
  end

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : gBank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ[gi] <= 1'b0;
        rowQ[gi]  <= '0;
        colQ[gi]  <= '0;
        preQ[gi]  <= '0;
        actQ[gi]  <= '0;
      end else if (strobe.commit && (reqBank == BANK_W'(gi))) begin
        openQ[gi] <= 1'b1;
        rowQ[gi]  <= reqRow;
        colQ[gi]  <= newColC;
        preQ[gi]  <= newPreC;
        actQ[gi]  <= newActC;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busQ         <= '0;
      rspPreTime   <= '0;
      rspActTime   <= '0;
      rspColTime   <= '0;
      rspReadyTime <= '0;
    end else if (strobe.commit) begin
      busQ         <= readyC;
      rspPreTime   <= strobe.needPre ? preTimeC : '0;
      rspActTime   <= strobe.needAct ? actTimeC : '0;
      rspColTime   <= colTimeC;
      rspReadyTime <= readyC;
    end
  end
endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker
  import bank_timing_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int TIME_W    = 32,
  parameter int CNT_W     = 16,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 8,
  parameter int T_RP      = 3,
  parameter int T_CL      = 4,
  parameter int T_BURST   = 2,
  parameter int T_WR      = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic              reqWrite,
  input  logic [TIME_W-1:0] curTime,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspPre,
  output logic              rspAct,
  output logic [TIME_W-1:0] rspPreTime,
  output logic [TIME_W-1:0] rspActTime,
  output logic [TIME_W-1:0] rspColTime,
  output logic [TIME_W-1:0] rspReadyTime,
  output logic [CNT_W-1:0]  rdHitCount,
  output logic [CNT_W-1:0]  wrHitCount
);
  ctrlStrobe_t      strobe;
  logic             lookupOpen;
  logic [ROW_W-1:0] lookupRow;

  bank_timing_ctrl #(.ROW_W(ROW_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRow(reqRow), .lookupOpen(lookupOpen), .lookupRow(lookupRow),
    .strobe(strobe), .rspValid(rspValid), .rspHit(rspHit),
    .rspPre(rspPre), .rspAct(rspAct),
    .rdHitCount(rdHitCount), .wrHitCount(wrHitCount)
  );

  bank_timing_datapath #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .TIME_W(TIME_W),
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_CL(T_CL),
    .T_BURST(T_BURST), .T_WR(T_WR)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqBank(reqBank),
    .reqRow(reqRow), .curTime(curTime), .lookupOpen(lookupOpen),
    .lookupRow(lookupRow), .rspPreTime(rspPreTime),
    .rspActTime(rspActTime), .rspColTime(rspColTime),
    .rspReadyTime(rspReadyTime)
  );
endmodule

// File: rtl/bank_timing_tracker_chk.sv
module bank_timing_tracker_chk #(
  parameter int TIME_W  = 32,
  parameter int CNT_W   = 16,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_CL    = 4,
  parameter int T_BURST = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              rspValid,
  input logic              rspHit,
  input logic              rspPre,
  input logic              rspAct,
  input logic [TIME_W-1:0] rspPreTime,
  input logic [TIME_W-1:0] rspActTime,
  input logic [TIME_W-1:0] rspColTime,
  input logic [TIME_W-1:0] rspReadyTime,
  input logic [CNT_W-1:0]  rdHitCount,
  input logic [CNT_W-1:0]  wrHitCount
);
  logic [TIME_W-1:0] lastReady;
  logic              seenRsp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastReady <= '0;
      seenRsp   <= 1'b0;
    end else if (rspValid) begin
      lastReady <= rspReadyTime;
      seenRsp   <= 1'b1;
    end
  end

  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  a_r2_hit_needs_no_row_cmds: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> (!rspPre && !rspAct));
  a_r3_act_after_pre_done: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspPre) |-> (rspActTime >= rspPreTime + TIME_W'(T_RP)));
  a_r4_col_after_rcd: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspAct) |-> (rspColTime >= rspActTime + TIME_W'(T_RCD)));
  a_r5_col_respects_bus: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && seenRsp) |-> (rspColTime + TIME_W'(T_CL) >= lastReady));
  a_r6_bursts_do_not_overlap: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && seenRsp) |-> (rspReadyTime >= lastReady + TIME_W'(T_BURST)));
  a_r9_counters_still_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> ($stable(rdHitCount) && $stable(wrHitCount)));
endmodule

bind bank_timing_tracker bank_timing_tracker_chk #(
  .TIME_W(TIME_W), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RP(T_RP),
  .T_CL(T_CL), .T_BURST(T_BURST)
) uChk (.*);

// File: tb/bank_timing_tracker_test.sv
`timescale 1ns/1ps
module bank_timing_tracker_test;
  localparam int NB = 4, RW = 8, TW = 32, CW = 16;
  localparam int TRCD = 3, TRAS = 8, TRP = 3, TCL = 4, TBURST = 2, TWR = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqBank = '0;
  logic [RW-1:0] reqRow = '0;
  logic          reqWrite = 1'b0;
  logic [TW-1:0] curTime = '0;
  logic          rspValid, rspHit, rspPre, rspAct;
  logic [TW-1:0] rspPreTime, rspActTime, rspColTime, rspReadyTime;
  logic [CW-1:0] rdHitCount, wrHitCount;

  bank_timing_tracker uut (.*);

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  longint tNow = 0;

  // independent model state
  bit     mOpen [NB];
  int     mRow  [NB];
  longint mCol  [NB], mPre [NB], mAct [NB];
  longint mBus = 0;
  int     mRdHits = 0, mWrHits = 0;

  function automatic longint lmax(longint a, longint b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    tNow++;
    curTime = TW'(tNow);
  endtask

  task automatic issue(int b, int r, bit w);
    bit     eHit, ePre;
    longint ePreT, eActT, eCol, eReady, actFloor;
    eHit  = mOpen[b] && (mRow[b] == r);
    ePre  = mOpen[b] && !eHit;
    ePreT = 0;
    eActT = 0;
    actFloor = mAct[b];
    if (eHit) begin
      eCol = lmax(mCol[b], tNow);                         // R2
    end else begin
      if (ePre) begin
        ePreT    = lmax(mPre[b], tNow);                   // R3
        actFloor = lmax(mAct[b], ePreT + TRP);
      end
      eActT   = lmax(actFloor, tNow);                     // R4
      mPre[b] = eActT + TRAS;
      eCol    = eActT + TRCD;
    end
    eCol   = lmax(eCol, lmax(mBus - TCL, 0));             // R5
    eReady = eCol + TCL + TBURST;                         // R6
    mAct[b] = actFloor;
    mCol[b] = eCol + TBURST;                              // R7
    if (w) mPre[b] = lmax(mPre[b], eReady + TWR);         // R8
    mBus = eReady;
    mOpen[b] = 1'b1;
    mRow[b]  = r;
    if (eHit && !w) mRdHits++;
    if (eHit && w)  mWrHits++;

    reqValid = 1'b1;
    reqBank  = 2'(b);
    reqRow   = RW'(r);
    reqWrite = w;
    step();
    reqValid = 1'b0;
    check("R10 rspValid", rspValid, 1);
    check("R2 hit flag", rspHit, eHit);
    check("R3 pre flag", rspPre, ePre);
    check("R4 act flag", rspAct, !eHit);
    check("R3 pre time", rspPreTime, ePreT);
    check("R4 act time", rspActTime, eActT);
    check("R5/R7/R8 col time", rspColTime, eCol);
    check("R6 ready time", rspReadyTime, eReady);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      mOpen[i] = 0; mRow[i] = 0; mCol[i] = 0; mPre[i] = 0; mAct[i] = 0;
    end
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1: reset state at the ports
    check("R1 rspValid after reset", rspValid, 0);
    check("R1 rdHitCount after reset", rdHitCount, 0);
    check("R1 wrHitCount after reset", wrHitCount, 0);
    check("R1 ready time after reset", rspReadyTime, 0);
    // R1: first access is a plain activate at now
    issue(2, 5, 0);
    check("R1 first activate at now", rspActTime, tNow - 1);
    // R10: idle cycle gives no response, state untouched
    step();
    check("R10 no response when idle", rspValid, 0);
    step();
    issue(2, 5, 0);
    check("R10 idle keeps open row (hit)", rspHit, 1);

    // sweep banks, rows, directions and gaps
    for (int g = 0; g < 3; g++)
      for (int w = 0; w < 2; w++)
        for (int r = 0; r < 3; r++)
          for (int b = 0; b < NB; b++) begin
            issue(b, r, w[0]);
            issue(b, r, !w[0]);
            issue(b, (r + 1) % 3, w[0]);
            for (int k = 0; k < g; k++) step();
          end

    // R8: write then immediate row change on the same bank
    issue(1, 7, 1);
    issue(1, 9, 0);
    // long idle stretch: all bounds lapse back to now
    for (int k = 0; k < 100; k++) step();
    issue(0, 11, 0);
    issue(3, 12, 1);
    issue(3, 12, 1);

    step();
    check("R9 read hit count", rdHitCount, mRdHits);
    check("R9 write hit count", wrHitCount, mWrHits);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule